// File: doc/BRIEF.md
# High-Speed Host Reset and Chirp Negotiator

This block is the host-side controller that resets a newly attached USB device and, when possible, negotiates high speed. On a start command it reads the two-bit line state and classifies the device. A low-speed device is reported at once and is not reset here. A full-speed device is put into reset: the block sets the transceiver controls so the bus is held at SE0 and chirp signalling is enabled, then watches for a device Chirp K. A device Chirp K counts only when it is long enough and qualified by high-speed receiver activity.

Once the device chirp has been accepted and has ended, the block waits a fixed response time. It then raises a no-PID chirp transmit request and drives alternating K and J symbols, each lasting a fixed number of clock cycles. The reset lasts at least a parameterised number of cycles. If a chirp train is running when that time is up, the current symbol is completed before the block stops. The block then returns the transceiver to normal operating mode, pulses `done_o` and reports the negotiated speed.

All durations are counted in clock cycles, derived from `CYC_PER_US`. When the design is elaborated, it rejects a symbol length outside 40 to 60 µs and a response latency longer than 100 µs.

Top module: `hsreset_ctl`

## Requirements
- R1: If `start_i` is high in idle while `line_state_i` is 2'b10, `done_o` pulses in the next cycle with `speed_o` = 2'b00 (low). `xcvr_sel_o` becomes 2'b10 and `term_sel_o` becomes 1. `op_mode_o` never becomes 2'b10.
- R2: If `start_i` is high in idle while `line_state_i` is 2'b01, the reset begins in the next cycle (t0). From then until `done_o`, the outputs are `xcvr_sel_o` = 2'b00, `term_sel_o` = 0 and `op_mode_o` = 2'b10.
- R3: `start_i` has no effect in these cases: the line state is 2'b00 or 2'b11, or a reset is already running. In these cases there is no `done_o`, no new reset, and `speed_o` keeps its value. `done_o` is a single-cycle pulse.
- R4: A device Chirp K is a cycle with `line_state_i` = 2'b10 and `hs_act_i` = 1. It is accepted only after at least DET_CYC = ceil(2.5·CYC_PER_US) consecutive such cycles. Shorter runs, and K line states without `hs_act_i`, are ignored.
- R5: If no device chirp is accepted, SE0 is held for exactly RESET_CYC cycles. After that, `done_o` pulses with `speed_o` = 2'b01 (full). The outputs then become `xcvr_sel_o` = 2'b01, `term_sel_o` = 1 and `op_mode_o` = 2'b00.
- R6: After an accepted device chirp, take the first cycle in which the device K is absent. The first host chirp cycle (`chirp_tx_o` = 1) comes exactly RESP_CYC+1 cycles after that cycle.
- R7: The host chirp train starts with K (`chirp_k_o` = 1) and then alternates K and J (`chirp_k_o` = 0). Each symbol lasts exactly SYM_CYC cycles.
- R8: The chirp train ends at the first symbol boundary at or after RESET_CYC cycles from t0. `done_o` then pulses with `speed_o` = 2'b10 (high). The outputs become `xcvr_sel_o` = 2'b00, `term_sel_o` = 0 and `op_mode_o` = 2'b00.
- R9: If the reset time runs out before the host chirp would start, the result is full speed at exactly RESET_CYC cycles. This covers both a device K that is still present and a pending response.
- R10: After reset, `speed_o` = 2'b01, the controls are at full-speed idle, `done_o` = 0 and `chirp_tx_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to classify and reset the attached device |
| line_state_i | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| hs_act_i | input | 1 | High-speed receiver activity (squelch off) |
| xcvr_sel_o | output | 2 | Transceiver select: 00 high, 01 full, 10 low speed |
| term_sel_o | output | 1 | Termination select |
| op_mode_o | output | 2 | Operating mode: 00 normal, 10 chirp |
| chirp_tx_o | output | 1 | No-PID chirp transmit active |
| chirp_k_o | output | 1 | Current host chirp symbol is K (1) or J (0) |
| done_o | output | 1 | One-cycle pulse at the end of classification or reset |
| speed_o | output | 2 | Negotiated speed: 00 low, 01 full, 10 high |

## Verification
The assertions check several properties on every cycle. Done is a single pulse. A low-speed result never passes through the reset phase. Every full- or high-speed result comes after the reset timer has expired, and a high-speed result also needs a symbol boundary. The response wait is entered only after an accepted chirp. The chirp symbol holds between boundaries and flips at each one, and the debounce flag rises only on a K input. Some properties need the bench's scenarios instead. These are the exact reset length, the response latency measured from the end of the device K, the exact debounce threshold, and the choice between full and high speed near the expiry boundary. The bench sweeps K run lengths and start offsets to cover them.

// File: rtl/hsreset_pkg.sv
// Package: shared encodings for the high-speed reset negotiator.
// Assumes the two-bit line state and transceiver control encodings below.
package hsreset_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SE0   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CHIRP = 2'd3
    } rst_state_e;

    localparam logic [1:0] LINE_SE0 = 2'b00;
    localparam logic [1:0] LINE_J   = 2'b01;
    localparam logic [1:0] LINE_K   = 2'b10;

    localparam logic [1:0] SPD_LOW  = 2'b00;
    localparam logic [1:0] SPD_FULL = 2'b01;
    localparam logic [1:0] SPD_HIGH = 2'b10;

    localparam logic [1:0] XCV_HS = 2'b00;
    localparam logic [1:0] XCV_FS = 2'b01;
    localparam logic [1:0] XCV_LS = 2'b10;

    localparam logic [1:0] OPM_NORMAL = 2'b00;
    localparam logic [1:0] OPM_CHIRP  = 2'b10;
endpackage

// File: rtl/hsreset_timer.sv
// Module: saturating cycle timer. Counts while run is high, clears when run
// is low, and flags the cycle in which LIMIT cycles of running are complete.
// Assumes LIMIT >= 1.
module hsreset_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [W-1:0] cnt_q;

    // Purpose: count running cycles, holding at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != W'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == W'(LIMIT - 1));

    // R5: once the timer has expired, it stays expired while it keeps running.
    p_timer_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(expired)) |-> expired);
endmodule

// File: rtl/hsreset_kfilter.sv
// Module: device Chirp K debounce. Counts consecutive qualified K cycles
// while enabled and flags acceptance after DET cycles. A shorter run is
// discarded. Assumes DET >= 1.
module hsreset_kfilter #(
    parameter int unsigned DET = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic kline,
    output logic accepted
);
    localparam int W = $clog2(DET + 1);

    logic [W-1:0] run_q;

    // Purpose: count consecutive qualified K cycles, saturating at DET.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q <= '0;
        end else if (kline) begin
            if (run_q != W'(DET)) begin
                run_q <= run_q + 1'b1;
            end
        end else if (run_q != W'(DET)) begin
            run_q <= '0;
        end
    end

    assign accepted = (run_q == W'(DET));

    // R4: acceptance can only appear right after a qualified K cycle.
    p_accept_on_k_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accepted) |-> $past(kline));
endmodule

// File: rtl/hsreset_symgen.sv
// Module: host chirp symbol generator. While run is high, it emits symbols of
// SYM cycles each, starting with K and alternating. It flags the last cycle
// of each symbol.
module hsreset_symgen #(
    parameter int unsigned SYM = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sym_k,
    output logic sym_last
);
    localparam int W = $clog2(SYM);

    logic [W-1:0] cnt_q;
    logic         k_q;

    // Purpose: step through a symbol and toggle K/J at its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            k_q   <= 1'b1;
        end else if (sym_last) begin
            cnt_q <= '0;
            k_q   <= ~k_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sym_last = (cnt_q == W'(SYM - 1));
    assign sym_k    = k_q;

    // R7: the symbol holds between boundaries.
    p_sym_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(sym_last)) |-> $stable(sym_k));
    // R7: the symbol flips at every boundary.
    p_sym_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(sym_last)) |-> (sym_k != $past(sym_k)));
endmodule

// File: rtl/hsreset_ctl.sv
// Module: host reset and high-speed chirp negotiator (top).
// It classifies the device on start and drives SE0 for a full-speed device.
// It accepts a debounced device Chirp K, answers with a timed K/J train, and
// reports the speed with a done pulse. All durations are in clock cycles.
// Assumes line_state_i and hs_act_i are already synchronous to clk.
module hsreset_ctl
    import hsreset_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 60,
    parameter int unsigned SYM_CYC    = 3000,
    parameter int unsigned RESP_CYC   = 600,
    parameter int unsigned RESET_CYC  = 600000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] line_state_i,
    input  logic       hs_act_i,
    output logic [1:0] xcvr_sel_o,
    output logic       term_sel_o,
    output logic [1:0] op_mode_o,
    output logic       chirp_tx_o,
    output logic       chirp_k_o,
    output logic       done_o,
    output logic [1:0] speed_o
);
    localparam int unsigned DET_CYC  = (5 * CYC_PER_US + 1) / 2;
    localparam int unsigned SYM_MIN  = 40 * CYC_PER_US;
    localparam int unsigned SYM_MAX  = 60 * CYC_PER_US;
    localparam int unsigned RESP_MAX = 100 * CYC_PER_US;

    // Elaboration checks on the timing windows.
    if (SYM_CYC < SYM_MIN || SYM_CYC > SYM_MAX) begin : g_bad_sym
        $error("hsreset_ctl: SYM_CYC outside the 40..60 us window");
    end
    if (RESP_CYC < 1 || RESP_CYC + 1 > RESP_MAX) begin : g_bad_resp
        $error("hsreset_ctl: RESP_CYC exceeds the 100 us response limit");
    end
    if (RESET_CYC < 2) begin : g_bad_reset
        $error("hsreset_ctl: RESET_CYC too small");
    end

    rst_state_e state_q;
    logic [1:0] speed_q;
    logic       done_q;
    logic       kline;
    logic       k_ok;
    logic       rst_exp;
    logic       resp_exp;
    logic       sym_k;
    logic       sym_last;

    assign kline = (line_state_i == LINE_K) && hs_act_i;

    hsreset_timer #(.LIMIT(RESET_CYC)) u_rst_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != ST_IDLE),
        .expired (rst_exp)
    );

    hsreset_timer #(.LIMIT(RESP_CYC)) u_resp_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_WAIT),
        .expired (resp_exp)
    );

    hsreset_kfilter #(.DET(DET_CYC)) u_kfilter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state_q == ST_SE0),
        .kline    (kline),
        .accepted (k_ok)
    );

    hsreset_symgen #(.SYM(SYM_CYC)) u_symgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == ST_CHIRP),
        .sym_k    (sym_k),
        .sym_last (sym_last)
    );

    // Purpose: sequence classification, SE0 reset, response wait and chirp train.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            speed_q <= SPD_FULL;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && line_state_i == LINE_K) begin
                        speed_q <= SPD_LOW;
                        done_q  <= 1'b1;
                    end else if (start_i && line_state_i == LINE_J) begin
                        state_q <= ST_SE0;
                    end
                end
                ST_SE0: begin
                    if (rst_exp) begin
                        state_q <= ST_IDLE;
                        speed_q <= SPD_FULL;
                        done_q  <= 1'b1;
                    end else if (k_ok && !kline) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rst_exp) begin
                        state_q <= ST_IDLE;
                        speed_q <= SPD_FULL;
                        done_q  <= 1'b1;
                    end else if (resp_exp) begin
                        state_q <= ST_CHIRP;
                    end
                end
                ST_CHIRP: begin
                    if (sym_last && rst_exp) begin
                        state_q <= ST_IDLE;
                        speed_q <= SPD_HIGH;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: derive transceiver controls from the phase and the last speed.
    always_comb begin
        xcvr_sel_o = XCV_FS;
        term_sel_o = 1'b1;
        op_mode_o  = OPM_NORMAL;
        if (state_q != ST_IDLE) begin
            xcvr_sel_o = XCV_HS;
            term_sel_o = 1'b0;
            op_mode_o  = OPM_CHIRP;
        end else if (speed_q == SPD_HIGH) begin
            xcvr_sel_o = XCV_HS;
            term_sel_o = 1'b0;
        end else if (speed_q == SPD_LOW) begin
            xcvr_sel_o = XCV_LS;
        end
    end

    assign chirp_tx_o = (state_q == ST_CHIRP);
    assign chirp_k_o  = (state_q == ST_CHIRP) && sym_k;
    assign done_o     = done_q;
    assign speed_o    = speed_q;

    // R1: a low-speed result never comes out of the reset phase.
    p_ls_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && speed_o == SPD_LOW) |-> ($past(state_q) == ST_IDLE));
    // R3: done is a single-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3: a start on an SE0 or SE1 line leaves the block idle.
    p_bad_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE && $past(start_i) && $past(line_state_i) != LINE_J
         && $past(line_state_i) != LINE_K) |-> (state_q == ST_IDLE && !done_o));
    // R4: the response wait starts only after an accepted device chirp.
    p_wait_needs_k_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) == ST_SE0) |-> $past(k_ok));
    // R5: a full or high result comes only after the reset time has run out.
    p_min_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && speed_o != SPD_LOW) |-> $past(rst_exp));
    // R8: a high-speed result ends on a complete chirp symbol.
    p_hs_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && speed_o == SPD_HIGH) |-> ($past(state_q) == ST_CHIRP && $past(sym_last)));
endmodule

// File: tb/hsreset_ctl_tb_top.sv
// Bench: sweeps device chirp lengths and start offsets on a small config.
module hsreset_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_PER_US = 1;
    localparam int SYM_CYC    = 45;
    localparam int RESP_CYC   = 7;
    localparam int RESET_CYC  = 400;
    localparam int DET_CYC    = 3;  // ceil(2.5 * CYC_PER_US)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] line_state_i = 2'b00;
    logic       hs_act_i = 1'b0;
    logic [1:0] xcvr_sel_o;
    logic       term_sel_o;
    logic [1:0] op_mode_o;
    logic       chirp_tx_o;
    logic       chirp_k_o;
    logic       done_o;
    logic [1:0] speed_o;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hsreset_ctl #(
        .CYC_PER_US (CYC_PER_US),
        .SYM_CYC    (SYM_CYC),
        .RESP_CYC   (RESP_CYC),
        .RESET_CYC  (RESET_CYC)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .line_state_i (line_state_i),
        .hs_act_i     (hs_act_i),
        .xcvr_sel_o   (xcvr_sel_o),
        .term_sel_o   (term_sel_o),
        .op_mode_o    (op_mode_o),
        .chirp_tx_o   (chirp_tx_o),
        .chirp_k_o    (chirp_k_o),
        .done_o       (done_o),
        .speed_o      (speed_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pack the controls as {xcvr, term, opmode} for compact comparison.
    function automatic int ctl_word();
        return {xcvr_sel_o, term_sel_o, op_mode_o};
    endfunction

    task automatic run_ls();
        @(negedge clk);
        line_state_i = 2'b10; hs_act_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; line_state_i = 2'b01;
        check(done_o && speed_o == 2'b00, "R1", "low-speed done/speed",
              {done_o, speed_o}, 3'b100);
        check(ctl_word() == 5'b10_1_00, "R1", "low-speed controls", ctl_word(), 5'b10100);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!done_o && op_mode_o == 2'b00, "R1", "no SE0 phase after low speed",
                  {done_o, op_mode_o}, 0);
        end
    endtask

    task automatic run_ignored(input logic [1:0] lv);
        logic [1:0] spd0;
        spd0 = speed_o;
        @(negedge clk);
        line_state_i = lv; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(!done_o && op_mode_o == 2'b00 && speed_o == spd0, "R3",
                  "start ignored on SE0/SE1 line", {done_o, op_mode_o, speed_o}, {1'b0, 2'b00, spd0});
            @(negedge clk);
        end
    endtask

    // Full-speed attach; device K on cycles [a, a+n) relative to t0.
    task automatic run_fs(input int a, input int n, input bit hs, input int restart_at);
        int    limit     = RESET_CYC + SYM_CYC + 8;
        bit    acc       = hs && (n >= DET_CYC);
        int    c0        = a + n;
        int    s         = c0 + RESP_CYC + 1;
        bit    exp_hs    = acc && (s < RESET_CYC);
        int    exp_total = exp_hs ? s + ((RESET_CYC - s + SYM_CYC - 1) / SYM_CYC) * SYM_CYC
                                  : RESET_CYC;
        int    first_tx  = -1;
        int    done_at   = -1;
        int    pat_err   = 0;
        int    ctl_err   = 0;
        string req;
        if (exp_hs)               req = "R8";
        else if (!acc)            req = (n > 0) ? "R4" : "R5";
        else                      req = "R9";
        @(negedge clk);
        line_state_i = 2'b01; hs_act_i = 1'b0; start_i = 1'b1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            start_i = (i == restart_at);
            if (done_o) begin
                done_at = i;
                break;
            end
            if (ctl_word() != 5'b00_0_10) ctl_err++;
            if (chirp_tx_o) begin
                if (first_tx < 0) first_tx = i;
                if (chirp_k_o != (((i - first_tx) / SYM_CYC) % 2 == 0)) pat_err++;
            end
            if (i == restart_at) begin
                line_state_i = 2'b01; hs_act_i = 1'b0;
            end else if (i >= a && i < a + n) begin
                line_state_i = 2'b10; hs_act_i = hs;
            end else begin
                line_state_i = 2'b00; hs_act_i = 1'b0;
            end
        end
        start_i = 1'b0;
        line_state_i = 2'b00; hs_act_i = 1'b0;
        check(ctl_err == 0, "R2", "SE0/chirp controls during reset", ctl_err, 0);
        check(done_at == exp_total, exp_hs ? "R8" : "R5", "reset length in cycles",
              done_at, exp_total);
        check(speed_o == (exp_hs ? 2'b10 : 2'b01), req, "negotiated speed",
              speed_o, exp_hs ? 2 : 1);
        check(ctl_word() == (exp_hs ? 5'b00_0_00 : 5'b01_1_00), exp_hs ? "R8" : "R5",
              "controls after reset", ctl_word(), exp_hs ? 0 : 5'b01100);
        if (exp_hs) begin
            check(first_tx == s, "R6", "first host chirp cycle", first_tx, s);
            check(pat_err == 0, "R7", "K/J symbol pattern errors", pat_err, 0);
        end else begin
            check(first_tx == -1, req, "no host chirp without response", first_tx, -1);
        end
        @(negedge clk);
        check(!done_o && op_mode_o == 2'b00, "R3", "done is one pulse, no restart",
              {done_o, op_mode_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(speed_o == 2'b01 && ctl_word() == 5'b01_1_00 && !done_o && !chirp_tx_o,
              "R10", "reset state", {speed_o, ctl_word()}, {2'b01, 5'b01100});
        run_ignored(2'b00);
        run_ignored(2'b11);
        run_ls();
        run_fs(0, 0, 1'b0, -1);                 // no chirp at all
        for (int a = 0; a <= 8; a += 4) begin
            for (int n = 1; n <= DET_CYC + 2; n++) begin
                run_fs(a, n, 1'b1, -1);         // sweep around the debounce threshold
            end
        end
        run_fs(5, 10, 1'b0, -1);                // K line without receiver activity
        run_fs(RESET_CYC - RESP_CYC - 6, 4, 1'b1, -1);  // chirp starts one cycle before expiry
        run_fs(RESET_CYC - RESP_CYC - 5, 4, 1'b1, -1);  // response would start at expiry
        run_fs(RESET_CYC - 2 * SYM_CYC - RESP_CYC - 5, 4, 1'b1, -1); // exact symbol boundary
        run_fs(100, RESET_CYC, 1'b1, -1);       // device K never ends
        run_fs(10, 5, 1'b1, 2);                 // start during reset is ignored
        run_ls();                               // low speed after high speed
        run_ignored(2'b00);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule